// File: doc/BRIEF.md
# Interval Timer Register Port

This block is the processor-facing register logic of a three-channel interval timer. It decodes a two-bit address into three counter data ports and one control port. It accepts three kinds of command byte on the control port: a channel configuration, a single-channel count snapshot, and a multi-channel snapshot that can capture the count, the status or both. It steps the low and high bytes of the 16-bit counts for both directions of transfer.

The counting engines sit outside the block. Each channel appears here as three things: a live 16-bit count, its output level, and a load pulse. The load pulse tells the block that the channel has taken its newly written count into the counting element. The block sends each channel its configuration bits, and it sends the assembled initial count with a one-cycle strobe. Software can read a free-running channel through a frozen copy, so the two bytes it reads always belong to the same count.

Top module: `timer_reg_port`

## Requirements
- R1: A control-port write (address 3) with bits 7:6 equal to n (0..2) and bits 5:4 not equal to 00 configures channel n. Its bits 5:0 appear on that channel's `cfgBits` slice in the next cycle. The write also returns that channel's read and write byte pointers to the low byte and drops any snapshot the channel holds.
- R2: Access code 01 is low-byte only: one data write produces the count {00h, byte}. Access code 10 is high-byte only: one data write produces {byte, 00h}. In both cases the channel's `countWrStrobe` bit is high in the cycle after the write.
- R3: Access code 11 takes the low byte and then the high byte. The strobe and the assembled count are given only after the second byte.
- R4: A control write with bits 5:4 = 00 freezes channel n's live count. The reads that follow return the frozen value in the channel's access order. Once that value has been read in full, reads return the live count again.
- R5: While a frozen count or a frozen status is still unread, any further snapshot command of the same kind for that channel has no effect.
- R6: A control write with bits 7:6 = 11 is a multi-channel snapshot. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the status. Any set of channels can be selected at once.
- R7: A captured status byte holds the channel's output level in bit 7, its null-count flag in bit 6, and its last configuration bits 5:0 in bits 5:0.
- R8: The null-count flag is set by a configuration write and by a completed count write. It is cleared by the channel's `loadStrobe` pulse.
- R9: When both a status and a count are captured, the first read returns the status byte and the following reads return the count.
- R10: Each channel has separate read and write byte pointers, so reads and writes to one channel may be interleaved.
- R11: With no snapshot held, reads return the live count in the access order. A read of address 3 returns 00h. Data writes to a channel that has never been configured (access code 00) produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | 0..2 channel data port, 3 control port |
| wrEn | input | 1 | Write strobe, one byte per cycle |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe; advances read state at the clock edge |
| rdData | output | 8 | Read byte for `addr`, valid in the cycle of `rdEn` |
| liveCount | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| outLevel | input | 3 | Output level of each channel |
| loadStrobe | input | 3 | Pulse: channel took its new count into the counting element |
| countWrData | output | 48 | Last completed initial count per channel |
| countWrStrobe | output | 3 | One-cycle pulse per channel when a count write completes |
| cfgBits | output | 18 | Configuration bits 5:0 per channel, channel n at bits 6n+5:6n |

## Verification
The hardest case to reach is a channel that holds a captured status and a captured count at the same time, with one of them partly read, while the live count keeps moving and a repeated snapshot arrives. The stimulus first clears the null flag with a load pulse and sets the output level. It then issues a multi-channel snapshot covering two channels with different access codes and changes the live counts right away. Finally it reads status, low byte and high byte in turn, and then reads once more to confirm that the live value is back.

// File: rtl/timer_reg_pkg.sv
package timer_reg_pkg;
  localparam int NCNT    = 3;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int CFG_W   = 6;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NCNT);

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LOW   = 2'b01,
    ACC_HIGH  = 2'b10,
    ACC_BOTH  = 2'b11
  } access_e;

  typedef struct packed {
    logic [NCNT-1:0] ctrlWr;
    logic [NCNT-1:0] latchCnt;
    logic [NCNT-1:0] latchSts;
    logic [NCNT-1:0] dataWr;
    logic [NCNT-1:0] dataRd;
  } strobe_t;
endpackage

// File: rtl/timer_reg_ctrl.sv
module timer_reg_ctrl
  import timer_reg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output strobe_t           stb
);
  logic       ctrlHit;
  logic [1:0] sel;
  logic       isMulti;

  assign ctrlHit = wrEn && (addr == CTRL_ADDR);
  assign sel     = wrData[7:6];
  assign isMulti = (sel == 2'b11);

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_dec
    logic hitSel;
    assign hitSel = (sel == 2'(gi));
    assign stb.ctrlWr[gi]   = ctrlHit && hitSel && (wrData[5:4] != ACC_LATCH);
    assign stb.latchCnt[gi] = ctrlHit && ((hitSel && (wrData[5:4] == ACC_LATCH)) ||
                                          (isMulti && !wrData[5] && wrData[gi+1]));
    assign stb.latchSts[gi] = ctrlHit && isMulti && !wrData[4] && wrData[gi+1];
    assign stb.dataWr[gi]   = wrEn && (addr == ADDR_W'(gi));
    assign stb.dataRd[gi]   = rdEn && (addr == ADDR_W'(gi));
  end
endmodule

// File: rtl/timer_reg_dp.sv
module timer_reg_dp
  import timer_reg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                stb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic [NCNT*CNT_W-1:0]  liveCount,
  input  logic [NCNT-1:0]        outLevel,
  input  logic [NCNT-1:0]        loadStrobe,
  output logic [BYTE_W-1:0]      rdData,
  output logic [NCNT*CNT_W-1:0]  countWrData,
  output logic [NCNT-1:0]        countWrStrobe,
  output logic [NCNT*CFG_W-1:0]  cfgBits
);
  logic [BYTE_W-1:0] byteOut [NCNT];

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_ch
    logic [CFG_W-1:0]  cfgReg;
    logic              nullCnt;
    logic              wrPtr, rdPtr;
    logic [BYTE_W-1:0] lowHold;
    logic [CNT_W-1:0]  cntSnap;
    logic              cntHeld;
    logic [BYTE_W-1:0] stsSnap;
    logic              stsHeld;
    logic [CNT_W-1:0]  initCnt;
    logic              wrDone;
    access_e           acc;
    logic [CNT_W-1:0]  live, readSrc;
    logic              hiSel, readLast, wrFinish;

    assign acc      = access_e'(cfgReg[5:4]);
    assign live     = liveCount[gi*CNT_W +: CNT_W];
    assign readSrc  = cntHeld ? cntSnap : live;
    assign hiSel    = (acc == ACC_HIGH) || ((acc == ACC_BOTH) && rdPtr);
    assign readLast = (acc != ACC_BOTH) || rdPtr;
    assign byteOut[gi] = stsHeld ? stsSnap :
                         (hiSel ? readSrc[CNT_W-1 -: BYTE_W] : readSrc[BYTE_W-1:0]);
    assign wrFinish = stb.dataWr[gi] &&
                      ((acc == ACC_LOW) || (acc == ACC_HIGH) || ((acc == ACC_BOTH) && wrPtr));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgReg  <= '0;
        nullCnt <= 1'b0;
        wrPtr   <= 1'b0;
        rdPtr   <= 1'b0;
        lowHold <= '0;
        cntSnap <= '0;
        cntHeld <= 1'b0;
        stsSnap <= '0;
        stsHeld <= 1'b0;
        initCnt <= '0;
        wrDone  <= 1'b0;
      end else begin
        wrDone <= wrFinish;
        if (loadStrobe[gi]) nullCnt <= 1'b0;

        if (stb.dataRd[gi]) begin
          if (stsHeld) begin
            stsHeld <= 1'b0;
          end else begin
            if (acc == ACC_BOTH) rdPtr <= ~rdPtr;
            if (cntHeld && readLast) cntHeld <= 1'b0;
          end
        end

        if (stb.dataWr[gi]) begin
          unique case (acc)
            ACC_LOW:  initCnt <= {{(CNT_W-BYTE_W){1'b0}}, wrData};
            ACC_HIGH: initCnt <= {wrData, {(CNT_W-BYTE_W){1'b0}}};
            ACC_BOTH: begin
              if (wrPtr) initCnt <= {wrData, lowHold};
              else       lowHold <= wrData;
              wrPtr <= ~wrPtr;
            end
            default: ;
          endcase
          if (wrFinish) nullCnt <= 1'b1;
        end

        if (stb.latchCnt[gi] && !cntHeld) begin
          cntSnap <= live;
          cntHeld <= 1'b1;
        end
        if (stb.latchSts[gi] && !stsHeld) begin
          stsSnap <= {outLevel[gi], nullCnt, cfgReg};
          stsHeld <= 1'b1;
        end

        if (stb.ctrlWr[gi]) begin
          cfgReg  <= wrData[CFG_W-1:0];
          nullCnt <= 1'b1;
          wrPtr   <= 1'b0;
          rdPtr   <= 1'b0;
          cntHeld <= 1'b0;
          stsHeld <= 1'b0;
        end
      end
    end

    assign countWrData[gi*CNT_W +: CNT_W] = initCnt;
    assign countWrStrobe[gi]              = wrDone;
    assign cfgBits[gi*CFG_W +: CFG_W]     = cfgReg;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NCNT; i++)
      if (addr == ADDR_W'(i)) rdData = byteOut[i];
  end
endmodule

// File: rtl/timer_reg_port.sv
module timer_reg_port
  import timer_reg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [BYTE_W-1:0]      wrData,
  input  logic                   rdEn,
  output logic [BYTE_W-1:0]      rdData,
  input  logic [NCNT*CNT_W-1:0]  liveCount,
  input  logic [NCNT-1:0]        outLevel,
  input  logic [NCNT-1:0]        loadStrobe,
  output logic [NCNT*CNT_W-1:0]  countWrData,
  output logic [NCNT-1:0]        countWrStrobe,
  output logic [NCNT*CFG_W-1:0]  cfgBits
);
  strobe_t stb;

  timer_reg_ctrl u_ctrl (
    .addr   (addr),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdEn   (rdEn),
    .stb    (stb)
  );

  timer_reg_dp u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .addr          (addr),
    .wrData        (wrData),
    .liveCount     (liveCount),
    .outLevel      (outLevel),
    .loadStrobe    (loadStrobe),
    .rdData        (rdData),
    .countWrData   (countWrData),
    .countWrStrobe (countWrStrobe),
    .cfgBits       (cfgBits)
  );
endmodule

// File: rtl/timer_reg_chk.sv
module timer_reg_chk
  import timer_reg_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wrEn,
  input logic [BYTE_W-1:0]      wrData,
  input logic                   rdEn,
  input logic [BYTE_W-1:0]      rdData,
  input logic [NCNT*CNT_W-1:0]  liveCount,
  input logic [NCNT-1:0]        outLevel,
  input logic [NCNT-1:0]        loadStrobe,
  input logic [NCNT*CNT_W-1:0]  countWrData,
  input logic [NCNT-1:0]        countWrStrobe,
  input logic [NCNT*CFG_W-1:0]  cfgBits
);
  a_r1_cfg_follows: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == CTRL_ADDR && wrData[7:6] == 2'b00 && wrData[5:4] != 2'b00)
    |=> cfgBits[CFG_W-1:0] == $past(wrData[CFG_W-1:0]));

  a_r2_low_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && cfgBits[5:4] == 2'b01)
    |=> countWrStrobe[0] && countWrData[CNT_W-1:BYTE_W] == '0 &&
        countWrData[BYTE_W-1:0] == $past(wrData));

  a_r2_high_only: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && cfgBits[5:4] == 2'b10)
    |=> countWrStrobe[0] && countWrData[BYTE_W-1:0] == '0 &&
        countWrData[CNT_W-1:BYTE_W] == $past(wrData));

  a_r3_strobe_source: assert property (@(posedge clk) disable iff (!rstN)
    countWrStrobe[0] |-> $past(wrEn && addr == '0));

  a_r11_ctrl_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == CTRL_ADDR) |-> rdData == '0);

  a_r11_unconfigured_silent: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == '0 && cfgBits[5:4] == 2'b00) |=> !countWrStrobe[0]);
endmodule

bind timer_reg_port timer_reg_chk u_chk (.*);

// File: tb/timer_reg_port_tb.sv
module timer_reg_port_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic [47:0] liveCount = '0;
  logic [2:0]  outLevel = '0;
  logic [2:0]  loadStrobe = '0;
  logic [47:0] countWrData;
  logic [2:0]  countWrStrobe;
  logic [17:0] cfgBits;

  int checks = 0;
  int errors = 0;

  logic [7:0]  rdQ [$];
  string       rdTagQ [$];
  int          wrIdxQ [$];
  logic [15:0] wrValQ [$];
  string       wrTagQ [$];

  always #2 clk = ~clk;

  timer_reg_port u_dut (.*);

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (rdEn) begin
        if (rdQ.size() == 0) check(0, "read with no expectation", {40'd0, rdData}, 48'd0);
        else begin
          logic [7:0] e;
          string t;
          e = rdQ.pop_front();
          t = rdTagQ.pop_front();
          check(rdData == e, t, {40'd0, rdData}, {40'd0, e});
        end
      end
      if (countWrStrobe != 0) begin
        if (wrIdxQ.size() == 0) check(0, "unexpected count strobe", {45'd0, countWrStrobe}, 48'd0);
        else begin
          int i;
          logic [15:0] v;
          string t;
          i = wrIdxQ.pop_front();
          v = wrValQ.pop_front();
          t = wrTagQ.pop_front();
          check(countWrStrobe == 3'(1 << i) && countWrData[i*16 +: 16] == v, t,
                {29'd0, countWrStrobe, countWrData[i*16 +: 16]}, {29'd0, 3'(1 << i), v});
        end
      end
    end
  end

  task automatic wrByte(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic expectWr(int i, logic [15:0] v, string t);
    wrIdxQ.push_back(i); wrValQ.push_back(v); wrTagQ.push_back(t);
  endtask

  task automatic rdByte(logic [1:0] a, logic [7:0] e, string t);
    rdQ.push_back(e); rdTagQ.push_back(t);
    @(posedge clk); #1;
    addr = a; rdEn = 1'b1;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic setLive(int i, logic [15:0] v);
    liveCount[i*16 +: 16] = v;
  endtask

  task automatic pulseLoad(int i);
    @(posedge clk); #1;
    loadStrobe[i] = 1'b1;
    @(posedge clk); #1;
    loadStrobe[i] = 1'b0;
  endtask

  task automatic finishRun();
    check(rdQ.size() == 0 && wrIdxQ.size() == 0, "scoreboard drained",
          48'(rdQ.size() + wrIdxQ.size()), 48'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(rdData == 8'h00 && cfgBits == '0 && countWrStrobe == '0, "reset state",
          {21'd0, rdData, cfgBits, countWrStrobe}, 48'd0);

    // R11: an unconfigured channel ignores data writes
    wrByte(2'd2, 8'h99);
    check(countWrStrobe == 3'b000, "R11 unconfigured write silent", {45'd0, countWrStrobe}, 48'd0);

    // R1 + R3: two-byte configuration on channel 0
    wrByte(2'd3, 8'h34);
    check(cfgBits[5:0] == 6'h34, "R1 cfg bits channel 0", {42'd0, cfgBits[5:0]}, 48'h34);
    wrByte(2'd0, 8'h34);
    expectWr(0, 16'h1234, "R3 two-byte count");
    wrByte(2'd0, 8'h12);
    repeat (2) @(posedge clk);

    // R2: low-only on channel 1, high-only on channel 2
    wrByte(2'd3, 8'h50);
    expectWr(1, 16'h00AB, "R2 low-only count");
    wrByte(2'd1, 8'hAB);
    wrByte(2'd3, 8'hA2);
    check(cfgBits[17:12] == 6'h22, "R1 cfg bits channel 2", {42'd0, cfgBits[17:12]}, 48'h22);
    expectWr(2, 16'h7700, "R2 high-only count");
    wrByte(2'd2, 8'h77);
    repeat (2) @(posedge clk);

    // R11: live reads and control-port read
    setLive(0, 16'hBEEF);
    setLive(1, 16'h1111);
    rdByte(2'd0, 8'hEF, "R11 live low");
    rdByte(2'd0, 8'hBE, "R11 live high");
    rdByte(2'd1, 8'h11, "R11 live low-only");
    rdByte(2'd3, 8'h00, "R11 control read zero");

    // R4 + R5: snapshot holds, repeated snapshot ignored
    setLive(0, 16'h1357);
    wrByte(2'd3, 8'h00);
    setLive(0, 16'h2468);
    wrByte(2'd3, 8'h00);
    rdByte(2'd0, 8'h57, "R4 frozen low");
    rdByte(2'd0, 8'h13, "R5 frozen high after ignored snapshot");
    rdByte(2'd0, 8'h68, "R4 live low after snapshot");
    rdByte(2'd0, 8'h24, "R4 live high after snapshot");

    // R7 + R8: status with null set, then cleared by load
    wrByte(2'd3, 8'hE4);
    rdByte(2'd1, 8'h50, "R8 null set after write");
    pulseLoad(1);
    wrByte(2'd3, 8'hE4);
    rdByte(2'd1, 8'h10, "R8 null cleared by load");
    rdByte(2'd1, 8'h11, "R7 status read once");
    pulseLoad(0);
    outLevel[0] = 1'b1;
    wrByte(2'd3, 8'hE2);
    rdByte(2'd0, 8'hB4, "R7 status out level and cfg");

    // R6 + R9: channels 0 and 2, count and status together
    setLive(0, 16'hA5C3);
    setLive(2, 16'h9988);
    wrByte(2'd3, 8'hCA);
    setLive(0, 16'h0F0F);
    setLive(2, 16'h4400);
    wrByte(2'd3, 8'hCA);
    rdByte(2'd0, 8'hB4, "R9 status first channel 0");
    rdByte(2'd0, 8'hC3, "R6 frozen low channel 0");
    rdByte(2'd0, 8'hA5, "R6 frozen high channel 0");
    rdByte(2'd2, 8'h62, "R9 status first channel 2");
    rdByte(2'd2, 8'h99, "R6 frozen high-only channel 2");
    rdByte(2'd2, 8'h44, "R6 live after snapshot channel 2");

    // R10: interleaved reads and writes on channel 0
    setLive(0, 16'h4321);
    rdByte(2'd0, 8'h21, "R10 read low");
    wrByte(2'd0, 8'h01);
    rdByte(2'd0, 8'h43, "R10 read high after write low");
    expectWr(0, 16'h0201, "R10 write completes");
    wrByte(2'd0, 8'h02);
    repeat (2) @(posedge clk);

    // R1: configuration resets both pointers
    wrByte(2'd0, 8'h55);
    rdByte(2'd0, 8'h21, "R1 read low before reconfig");
    wrByte(2'd3, 8'h34);
    rdByte(2'd0, 8'h21, "R1 read pointer reset");
    wrByte(2'd0, 8'h66);
    expectWr(0, 16'h7766, "R1 write pointer reset");
    wrByte(2'd0, 8'h77);
    repeat (3) @(posedge clk);
    finishRun();
  end
endmodule